// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a clocked system and an external 128K x 8 asynchronous static RAM. The system hands it one byte-wide read or write at a time. The block then drives the memory's address lines and its two chip selects, which have opposite polarity. It also drives the write strobe and the output strobe, and it owns its side of the shared 8-bit data bus. The length of every phase is a whole number of system clocks. Each length is worked out at elaboration from the clock period and the memory's minimum nanosecond limits, so that no strobe is shorter than the memory needs and the two sides never drive the bus at the same time.

Requests use a valid/ready handshake. A request moves on the clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle, so the requester is held off for the whole of a memory cycle. The requester may keep `req_valid` high for as long as it likes, and its fields are looked at only on the transfer edge. Completion comes back as a one-cycle `rsp_valid` pulse. That channel has no back-pressure: the pulse is not repeated, and `rsp_rdata` holds the last read byte until the next read finishes.

Between transactions the memory is deselected, which puts it in standby, and the data bus is released.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever idle: `req_ready`=1, `sram_sel_n`=1, `sram_sel`=0, `sram_we_n`=1, `sram_oe_n`=1, `rsp_valid`=0 and the controller does not drive `sram_dq`.
- R2: A request transfers only on an edge where `req_valid` and `req_ready` are both high. Address, write flag (1 = write) and write byte are captured on that edge, and later changes to the request inputs have no effect on the transaction in flight. `req_ready` is low from the cycle after a transfer until the response cycle.
- R3: Read: from the cycle after the transfer, for C_RD = max(ceil(T_RC/P), ceil(T_AA/P)) cycles (18 at P = 4 ns), the outputs are `sram_sel_n`=0, `sram_sel`=1, `sram_oe_n`=0 and `sram_we_n`=1, with `sram_addr` equal to the captured address.
- R4: The read byte is sampled from `sram_dq` on the last read-phase cycle. `rsp_valid` is high for exactly the following cycle, and `rsp_rdata` holds that byte until the next read completes.
- R5: Write: from the cycle after the transfer, `sram_we_n`=0 for C_WL = max(ceil(T_WP/P), C_TA + ceil(T_DW/P)) cycles (16 at 4 ns), with both selects active and `sram_oe_n`=1. A recovery phase of C_WR = max(1, ceil(T_WC/P) - C_WL) cycles (2 at 4 ns) follows, with `sram_we_n`=1 and the selects still active. `rsp_valid` pulses in the cycle after recovery.
- R6: The controller drives the write byte on `sram_dq` from cycle C_TA = ceil(T_FLOAT/P) (8 at 4 ns) of the write-low phase, counted from 0, through the end of recovery. It never drives the bus while `sram_oe_n` is low.
- R7: `sram_addr` does not change while the memory stays selected.
- R8: A request already valid in a response cycle is accepted in that cycle. Back-to-back transactions are therefore separated by exactly one deselected cycle.
- R9: A byte written to an address reads back unchanged, including at address 0 and at address 2^17-1. Other addresses are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can transfer (idle) |
| req_addr | input | 17 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| sram_addr | output | 17 | Memory address lines |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_sel | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq | inout | 8 | Shared data bus |

## Verification
The bench runs the following request patterns:
- Isolated writes and reads, with idle gaps between them. These show that each phase has the right length measured from a clean idle start.
- Back-to-back requests with `req_valid` held high. These separate "accepted in the response cycle" from "accepted one cycle late", because the single deselected cycle between transactions is visible.
- Changes to the request inputs during a transaction. These tell fields captured at the handshake apart from fields that are read live.
- Reads of addresses that were never written, which return a fill pattern the memory model computes from the address.
- Writes and reads at both ends of the address range.

The second and third read-data checks distinguish a read sampled at the end of the phase from data left on `rsp_rdata` by an earlier read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_WLOW = 2'd2,
    PH_WREC = 2'd3
  } phase_t;

  // clock cycles covering a nanosecond minimum, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned C_RD = 18,
  parameter int unsigned C_WL = 16,
  parameter int unsigned C_WR = 2,
  parameter int unsigned C_TA = 8,
  parameter int unsigned CW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          accept,
  output phase_t        phase,
  output logic          last,
  output logic          drv_en,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    unique case (phase)
      PH_READ: len_m1 = CW'(C_RD - 1);
      PH_WLOW: len_m1 = CW'(C_WL - 1);
      PH_WREC: len_m1 = CW'(C_WR - 1);
      default: len_m1 = '0;
    endcase
  end

  assign last   = (cnt == len_m1);
  assign drv_en = ((phase == PH_WLOW) && (cnt >= CW'(C_TA))) || (phase == PH_WREC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (req_valid) phase <= req_write ? PH_WLOW : PH_READ;
        end
        PH_READ: begin
          if (last) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WLOW: begin
          if (last) begin
            phase <= PH_WREC;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WREC: begin
          if (last) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_HOLD_OFF_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |-> (cnt < CW'(C_RD))); // R3
  AST_WLOW_TO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_WLOW) && last) |=> (phase == PH_WREC)); // R5
endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  phase_t        phase,
  input  logic          last,
  input  logic          drv_en,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_sel_n,
  output logic          sram_sel,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  inout  wire  [DW-1:0] sram_dq
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if ((phase == PH_READ) && last) rdata <= sram_dq;
    end
  end

  assign active     = (phase != PH_IDLE);
  assign sram_addr  = addr_q;
  assign sram_sel_n = !active;
  assign sram_sel   = active;
  assign sram_we_n  = (phase != PH_WLOW);
  assign sram_oe_n  = (phase != PH_READ);
  assign sram_dq    = drv_en ? wdata_q : {DW{1'bz}};

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> sram_oe_n); // R6
  AST_WE_BLOCKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && !sram_sel_n && sram_sel)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_sel_n && $past(!sram_sel_n)) |-> $stable(sram_addr)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sram_sel_n |-> (!sram_sel && sram_we_n && sram_oe_n && !drv_en)); // R1
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 4,
  parameter int unsigned T_RC_NS    = 70,
  parameter int unsigned T_AA_NS    = 70,
  parameter int unsigned T_WC_NS    = 70,
  parameter int unsigned T_WP_NS    = 50,
  parameter int unsigned T_DW_NS    = 30,
  parameter int unsigned T_FLOAT_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  inout  wire  [DATA_W-1:0] sram_dq
);
  localparam int unsigned C_RD  = umax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
  localparam int unsigned C_TA  = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int unsigned C_DWC = ns_to_cyc(T_DW_NS, CLK_NS);
  localparam int unsigned C_WL  = umax(ns_to_cyc(T_WP_NS, CLK_NS), C_TA + C_DWC);
  localparam int unsigned C_WCC = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned C_WR  = (C_WCC > C_WL + 1) ? (C_WCC - C_WL) : 1;
  localparam int unsigned C_MAX = umax(umax(C_RD, C_WL), C_WR);
  localparam int unsigned CW    = $clog2(C_MAX + 1);

  phase_t phase;
  logic   accept, last, drv_en;

  sram_seq #(
    .C_RD(C_RD), .C_WL(C_WL), .C_WR(C_WR), .C_TA(C_TA), .CW(CW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .phase     (phase),
    .last      (last),
    .drv_en    (drv_en),
    .done      (rsp_valid)
  );

  sram_pins #(.AW(ADDR_W), .DW(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .phase      (phase),
    .last       (last),
    .drv_en     (drv_en),
    .rdata      (rsp_rdata),
    .sram_addr  (sram_addr),
    .sram_sel_n (sram_sel_n),
    .sram_sel   (sram_sel),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq    (sram_dq)
  );

  AST_RSP_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && sram_sel_n)); // R8
endmodule

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;
  localparam int P    = 4;
  localparam int AW   = 17;
  localparam int C_RD = (70 + P - 1) / P;
  localparam int C_TA = (30 + P - 1) / P;
  localparam int C_WP = (50 + P - 1) / P;
  localparam int C_DW = (30 + P - 1) / P;
  localparam int C_WL = (C_WP > C_TA + C_DW) ? C_WP : C_TA + C_DW;
  localparam int C_WC = (70 + P - 1) / P;
  localparam int C_WR = (C_WC > C_WL + 1) ? C_WC - C_WL : 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, sram_sel_n, sram_sel, sram_we_n, sram_oe_n;
  logic [7:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  wire  [7:0] sram_dq;

  int vecs = 0, errs = 0, cyc = 0;

  always #(P/2) clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_sel_n(sram_sel_n), .sram_sel(sram_sel), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
  );

  // behavioural memory device
  logic [7:0] dev_mem [int];
  logic [7:0] dev_out = '0;
  logic dev_drive;
  function automatic logic [7:0] fill(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction
  assign dev_drive = !sram_sel_n && sram_sel && !sram_oe_n && sram_we_n;
  assign sram_dq = dev_drive ? dev_out : 8'bz;
  always @(negedge clk) begin
    int a;
    a = int'(sram_addr);
    dev_out <= dev_mem.exists(a) ? dev_mem[a] : fill(a);
  end
  always @(posedge sram_we_n)
    if (!sram_sel_n && sram_sel) dev_mem[int'(sram_addr)] = sram_dq;

  // reference model
  logic [7:0] exp_mem [int];
  int r_ph = 0, r_cnt = 0, r_a = 0;
  logic r_done = 1'b0, r_w = 1'b0;
  logic [7:0] r_d = '0, r_rd = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      r_ph = 0; r_cnt = 0; r_done = 1'b0; r_rd = '0;
    end else begin
      r_done = 1'b0;
      case (r_ph)
        0: if (req_valid) begin
             r_a = int'(req_addr); r_w = req_write; r_d = req_wdata;
             r_ph = r_w ? 2 : 1; r_cnt = 0;
           end
        1: if (r_cnt == C_RD - 1) begin
             r_rd = exp_mem.exists(r_a) ? exp_mem[r_a] : fill(r_a);
             r_ph = 0; r_done = 1'b1; r_cnt = 0;
           end else r_cnt++;
        2: if (r_cnt == C_WL - 1) begin
             exp_mem[r_a] = r_d; r_ph = 3; r_cnt = 0;
           end else r_cnt++;
        default: if (r_cnt == C_WR - 1) begin
             r_ph = 0; r_done = 1'b1; r_cnt = 0;
           end else r_cnt++;
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 2) begin
      chk("R1/R2 req_ready", 32'(req_ready), 32'(r_ph == 0));
      chk("R1/R3 sram_sel_n", 32'(sram_sel_n), 32'(r_ph == 0));
      chk("R1/R3 sram_sel", 32'(sram_sel), 32'(r_ph != 0));
      chk("R5 sram_we_n", 32'(sram_we_n), 32'(r_ph != 2));
      chk("R3 sram_oe_n", 32'(sram_oe_n), 32'(r_ph != 1));
      chk("R4/R8 rsp_valid", 32'(rsp_valid), 32'(r_done));
      chk("R4/R9 rsp_rdata", 32'(rsp_rdata), 32'(r_rd));
      if (r_ph != 0) chk("R2/R7 sram_addr", 32'(sram_addr), 32'(r_a));
      if ((r_ph == 2 && r_cnt >= C_TA) || r_ph == 3)
        chk("R6 sram_dq", 32'(sram_dq), 32'(r_d));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL R2 watchdog: no progress actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic xfer(input int a, input logic w, input logic [7:0] d);
    req_addr = AW'(a); req_write = w; req_wdata = d; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    // scramble request fields: must not affect the transaction (R2)
    req_addr = ~req_addr; req_wdata = ~req_wdata; req_write = ~req_write;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready || rsp_valid);
    @(posedge clk); #1;
  endtask

  initial begin
    int lcg;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R1 reset we_n/oe_n", {30'd0, sram_we_n, sram_oe_n}, 32'd3);
    chk("R1 reset selects", {30'd0, sram_sel_n, sram_sel}, 32'd2);
    @(posedge clk); #1;
    // R9 ends of the address range
    xfer(0, 1'b1, 8'hA5);           wait_idle();
    xfer(0, 1'b0, 8'h00);           wait_idle();
    xfer((1 << AW) - 1, 1'b1, 8'h3C); wait_idle();
    xfer((1 << AW) - 1, 1'b0, 8'h00); wait_idle();
    xfer(0, 1'b0, 8'h00);           wait_idle();
    // unwritten location returns fill
    xfer(32'h12345, 1'b0, 8'h00);   wait_idle();
    // R8 back-to-back with valid held
    xfer(5, 1'b1, 8'h11);
    xfer(6, 1'b1, 8'h22);
    xfer(5, 1'b0, 8'h00);
    xfer(6, 1'b0, 8'h00);
    xfer(7, 1'b0, 8'h00);
    wait_idle();
    // mixed traffic over a small address window
    lcg = 7;
    for (int i = 0; i < 60; i++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      xfer(lcg % 12, lcg[12], 8'(lcg >> 16));
      if (lcg[4]) repeat (lcg % 5) @(posedge clk);
    end
    wait_idle();
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule